// File: doc/BRIEF.md
# Card Host Interrupt Status Block

This block gathers the interrupt causes of a memory-card host controller. Single-cycle event pulses from the command, transfer and error engines are caught in two sticky status registers, one for normal events and one for errors. Card insertion and card removal come from edges of a card-present level. A status-enable register for each set decides which events may latch. A signal-enable register for each set decides which latched bits may raise the interrupt line. Software clears a latched bit by writing a one to it.

Software reaches the block through a 16-bit port with byte addresses. Reads are combinational on the address. A write takes effect at the clock edge where `regWrEn` is high. The top bit of the normal status register is not a stored flag. It reports whether any error status bit is latched, and it drops only once every error bit has been cleared. All inputs are taken to be synchronous to `clk`.

Top module: `hisc_top`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low.
- R2: The register map is as follows. 0x00 holds normal status. 0x02 holds error status. 0x04 holds the normal status-enable, writable bits 0x01FF. 0x06 holds the error status-enable, writable bits 0x01FF. 0x08 holds the normal signal-enable, writable bits 0x81FF. 0x0A holds the error signal-enable, writable bits 0x01FF. Any other address reads 0 and ignores writes, and bits outside a register's mask read 0.
- R3: `normPulse[5:0]` set normal status bits 5:0, and `normPulse[6]` sets normal status bit 8. A bit is set at the next clock edge only when its normal status-enable bit is 1.
- R4: A 0-to-1 change of `cardPresent` sets normal status bit 6, and a 1-to-0 change sets bit 7, each gated by its status-enable bit.
- R5: `errPulse[k]` sets error status bit k at the next edge only when error status-enable bit k is 1.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Clearing a status-enable bit does not clear a bit that is already latched.
- R7: An event that arrives in the same cycle as a write-1-to-clear of its bit wins, so the bit stays set.
- R8: Normal status bit 15 reads as the OR of all error status bits. Writing to it has no effect, and it reads 0 once every error bit is cleared.
- R9: `irqOut` is a register. One cycle after any latched normal bit has its normal signal-enable bit set, it is high. It is also high one cycle after normal signal-enable bit 15 is 1 while a latched error bit has its error signal-enable bit set. Otherwise it is low one cycle later.
- R10: While the normal signal-enable register is 0, `irqOut` stays low whatever is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address of the register accessed |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| normPulse | input | 7 | Normal event pulses (bit 6 is the card interrupt) |
| errPulse | input | 9 | Error event pulses |
| cardPresent | input | 1 | Card-present level |
| irqOut | output | 1 | Interrupt request level |

## Verification
Two situations are hard to reach from the ports. The first is a clearing write that lands on the same edge as a fresh event on the same bit. The second is the summary bit in the normal register, which stays up while errors remain and drops only after the last error is cleared through the other register. Directed steps cover both. A pulse is driven together with the clearing write, and the errors are cleared one at a time while the normal register is read between clears. A long run with random addresses, writes, sparse pulses and occasional card toggles follows. Every cycle it is compared against a behavioural model of all six registers and the interrupt line.

// File: rtl/hisc_pkg.sv
package hisc_pkg;
  // byte offsets of the six registers
  localparam int OFF_NSTAT = 'h00;
  localparam int OFF_ESTAT = 'h02;
  localparam int OFF_NEN   = 'h04;
  localparam int OFF_EEN   = 'h06;
  localparam int OFF_NSIG  = 'h08;
  localparam int OFF_ESIG  = 'h0A;

  // stored bits of the normal status register (bits 8:0)
  localparam int NORM_BITS = 9;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_NSTAT, SEL_ESTAT, SEL_NEN, SEL_EEN, SEL_NSIG, SEL_ESIG
  } rdSel_e;

  typedef struct packed {
    logic   clrNorm;
    logic   clrErr;
    logic   wrNormEn;
    logic   wrErrEn;
    logic   wrNormSig;
    logic   wrErrSig;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/hisc_regdec.sv
module hisc_regdec
  import hisc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  output regStrobe_t    strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    case (regAddr)
      AW'(OFF_NSTAT): begin strobe.rdSel = SEL_NSTAT; strobe.clrNorm   = regWrEn; end
      AW'(OFF_ESTAT): begin strobe.rdSel = SEL_ESTAT; strobe.clrErr    = regWrEn; end
      AW'(OFF_NEN):   begin strobe.rdSel = SEL_NEN;   strobe.wrNormEn  = regWrEn; end
      AW'(OFF_EEN):   begin strobe.rdSel = SEL_EEN;   strobe.wrErrEn   = regWrEn; end
      AW'(OFF_NSIG):  begin strobe.rdSel = SEL_NSIG;  strobe.wrNormSig = regWrEn; end
      AW'(OFF_ESIG):  begin strobe.rdSel = SEL_ESIG;  strobe.wrErrSig  = regWrEn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/hisc_status.sv
module hisc_status
  import hisc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int ERR_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic [DW-1:0]       regWrData,
  input  logic [6:0]          normPulse,
  input  logic [ERR_BITS-1:0] errPulse,
  input  logic                cardPresent,
  output logic [DW-1:0]       regRdData,
  output logic                irqOut,
  output logic [DW-1:0]       normStatQ,
  output logic [DW-1:0]       errStatQ,
  output logic [DW-1:0]       normEnQ,
  output logic [DW-1:0]       errEnQ,
  output logic [DW-1:0]       normSigQ,
  output logic [DW-1:0]       errSigQ
);
  localparam int SUM_BIT = DW - 1;
  localparam logic [DW-1:0] NSTAT_MASK = {{(DW-NORM_BITS){1'b0}}, {NORM_BITS{1'b1}}};
  localparam logic [DW-1:0] NSIG_MASK  = NSTAT_MASK | {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ERR_MASK   = {{(DW-ERR_BITS){1'b0}}, {ERR_BITS{1'b1}}};

  logic          prevCard;
  logic          cardIns, cardRem, errSummary, causeNow;
  logic [DW-1:0] normEvt, errEvt, normClr, errClr, normStatD, errStatD;

  assign cardIns = cardPresent & ~prevCard;
  assign cardRem = ~cardPresent & prevCard;
  assign normEvt = {{(DW-NORM_BITS){1'b0}}, normPulse[6], cardRem, cardIns, normPulse[5:0]};
  assign errEvt  = {{(DW-ERR_BITS){1'b0}}, errPulse};

  assign normClr = strobe.clrNorm ? regWrData : '0;
  assign errClr  = strobe.clrErr  ? regWrData : '0;

  // event term is ORed after the clear, so an arriving event wins
  assign normStatD = ((normStatQ & ~normClr) | (normEvt & normEnQ)) & NSTAT_MASK;
  assign errStatD  = ((errStatQ  & ~errClr)  | (errEvt  & errEnQ))  & ERR_MASK;

  assign errSummary = |errStatQ;
  assign causeNow   = (|(normStatQ & normSigQ)) |
                      (normSigQ[SUM_BIT] & (|(errStatQ & errSigQ)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCard  <= 1'b0;
      normStatQ <= '0;
      errStatQ  <= '0;
      normEnQ   <= '0;
      errEnQ    <= '0;
      normSigQ  <= '0;
      errSigQ   <= '0;
      irqOut    <= 1'b0;
    end else begin
      prevCard  <= cardPresent;
      normStatQ <= normStatD;
      errStatQ  <= errStatD;
      if (strobe.wrNormEn)  normEnQ  <= regWrData & NSTAT_MASK;
      if (strobe.wrErrEn)   errEnQ   <= regWrData & ERR_MASK;
      if (strobe.wrNormSig) normSigQ <= regWrData & NSIG_MASK;
      if (strobe.wrErrSig)  errSigQ  <= regWrData & ERR_MASK;
      irqOut    <= causeNow;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_NSTAT: regRdData = normStatQ | {errSummary, {(DW-1){1'b0}}};
      SEL_ESTAT: regRdData = errStatQ;
      SEL_NEN:   regRdData = normEnQ;
      SEL_EEN:   regRdData = errEnQ;
      SEL_NSIG:  regRdData = normSigQ;
      SEL_ESIG:  regRdData = errSigQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/hisc_top.sv
module hisc_top
  import hisc_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int ERR_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AW-1:0]       regAddr,
  input  logic                regWrEn,
  input  logic [DW-1:0]       regWrData,
  output logic [DW-1:0]       regRdData,
  input  logic [6:0]          normPulse,
  input  logic [ERR_BITS-1:0] errPulse,
  input  logic                cardPresent,
  output logic                irqOut
);
  regStrobe_t    strobe;
  logic [DW-1:0] normStatQ, errStatQ, normEnQ, errEnQ, normSigQ, errSigQ;

  hisc_regdec #(.AW(AW)) u_dec (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  hisc_status #(.DW(DW), .ERR_BITS(ERR_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .normPulse   (normPulse),
    .errPulse    (errPulse),
    .cardPresent (cardPresent),
    .regRdData   (regRdData),
    .irqOut      (irqOut),
    .normStatQ   (normStatQ),
    .errStatQ    (errStatQ),
    .normEnQ     (normEnQ),
    .errEnQ      (errEnQ),
    .normSigQ    (normSigQ),
    .errSigQ     (errSigQ)
  );
endmodule

// File: rtl/hisc_chk.sv
module hisc_chk
  import hisc_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int ERR_BITS = 9
) (
  input logic                clk,
  input logic                rstN,
  input logic [AW-1:0]       regAddr,
  input logic                regWrEn,
  input logic [DW-1:0]       regWrData,
  input logic [DW-1:0]       regRdData,
  input logic [6:0]          normPulse,
  input logic [ERR_BITS-1:0] errPulse,
  input logic                irqOut,
  input logic [DW-1:0]       normStatQ,
  input logic [DW-1:0]       errStatQ,
  input logic [DW-1:0]       normEnQ,
  input logic [DW-1:0]       errEnQ,
  input logic [DW-1:0]       normSigQ,
  input logic [DW-1:0]       errSigQ
);
  logic [DW-1:0] nPulseVec, ePulseVec;
  logic          causeNow, addrMapped;

  assign nPulseVec  = {{(DW-9){1'b0}}, normPulse[6], 2'b00, normPulse[5:0]};
  assign ePulseVec  = {{(DW-ERR_BITS){1'b0}}, errPulse};
  assign causeNow   = (|(normStatQ & normSigQ)) |
                      (normSigQ[DW-1] & (|(errStatQ & errSigQ)));
  assign addrMapped = (regAddr == AW'(OFF_NSTAT)) || (regAddr == AW'(OFF_ESTAT)) ||
                      (regAddr == AW'(OFF_NEN))   || (regAddr == AW'(OFF_EEN))   ||
                      (regAddr == AW'(OFF_NSIG))  || (regAddr == AW'(OFF_ESIG));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !addrMapped |-> (regRdData == '0)); // R2

  AST_SUMMARY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AW'(OFF_NSTAT)) |-> (regRdData[DW-1] == (|errStatQ))); // R8

  AST_NORM_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((normStatQ & $past(nPulseVec & normEnQ)) == $past(nPulseVec & normEnQ))); // R7

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errStatQ & $past(ePulseVec & errEnQ)) == $past(ePulseVec & errEnQ))); // R5

  AST_ERR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((errStatQ & ~$past(errStatQ) & ~$past(ePulseVec & errEnQ)) == '0)); // R5

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == AW'(OFF_ESTAT)) |=>
      ((errStatQ & $past(regWrData & ~ePulseVec)) == '0)); // R6

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(causeNow))); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (normSigQ == '0) |=> !irqOut); // R10
endmodule

bind hisc_top hisc_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regAddr     (regAddr),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .normPulse   (normPulse),
  .errPulse    (errPulse),
  .irqOut      (irqOut),
  .normStatQ   (normStatQ),
  .errStatQ    (errStatQ),
  .normEnQ     (normEnQ),
  .errEnQ      (errEnQ),
  .normSigQ    (normSigQ),
  .errSigQ     (errSigQ)
);

// File: tb/sim_hisc_top.sv
module sim_hisc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [6:0]  normPulse = '0;
  logic [8:0]  errPulse = '0;
  logic        cardPresent = 1'b0;
  logic        irqOut;

  always #10 clk = ~clk;

  hisc_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .normPulse(normPulse),
    .errPulse(errPulse), .cardPresent(cardPresent), .irqOut(irqOut)
  );

  int vectors = 0;
  int fails = 0;

  // behavioural reference state
  int unsigned mNs = 0, mEs = 0, mNe = 0, mEe = 0, mNsg = 0, mEsg = 0;
  bit mPrev = 0, mIrq = 0;

  function automatic int unsigned expRd(int unsigned a);
    case (a)
      'h00: return mNs | ((mEs != 0) ? 32'h8000 : 0);
      'h02: return mEs;
      'h04: return mNe;
      'h06: return mEe;
      'h08: return mNsg;
      'h0A: return mEsg;
      default: return 0;
    endcase
  endfunction

  function automatic bit modelCause();
    return ((mNs & mNsg) != 0) || (((mNsg & 'h8000) != 0) && ((mEs & mEsg) != 0));
  endfunction

  task automatic step(string tag);
    int unsigned a, d, nEv, nClr, eClr, nsN, esN, neN, eeN, nsgN, esgN;
    bit ins, rem, irqN;
    a = int'(regAddr);
    d = int'(regWrData);
    ins = cardPresent && !mPrev;
    rem = !cardPresent && mPrev;
    nEv = (int'(normPulse) & 'h3F) | (normPulse[6] ? 'h100 : 0) |
          (ins ? 'h40 : 0) | (rem ? 'h80 : 0);
    nClr = (regWrEn && a == 'h00) ? d : 0;
    eClr = (regWrEn && a == 'h02) ? d : 0;
    nsN  = ((mNs & ~nClr) | (nEv & mNe)) & 'h1FF;
    esN  = ((mEs & ~eClr) | (int'(errPulse) & mEe)) & 'h1FF;
    neN  = (regWrEn && a == 'h04) ? (d & 'h1FF)  : mNe;
    eeN  = (regWrEn && a == 'h06) ? (d & 'h1FF)  : mEe;
    nsgN = (regWrEn && a == 'h08) ? (d & 'h81FF) : mNsg;
    esgN = (regWrEn && a == 'h0A) ? (d & 'h1FF)  : mEsg;
    irqN = modelCause();
    @(posedge clk);
    mNs = nsN; mEs = esN; mNe = neN; mEe = eeN; mNsg = nsgN; mEsg = esgN;
    mIrq = irqN; mPrev = cardPresent;
    @(negedge clk);
    vectors++;
    if (regRdData !== 16'(expRd(int'(regAddr)))) begin
      fails++;
      $display("FAIL %s rdData addr=%h actual=%h expected=%h", tag, regAddr,
               regRdData, 16'(expRd(int'(regAddr))));
    end
    vectors++;
    if (irqOut !== mIrq) begin
      fails++;
      $display("FAIL %s irqOut actual=%b expected=%b", tag, irqOut, mIrq);
    end
    regWrEn = 1'b0;
    normPulse = '0;
    errPulse = '0;
  endtask

  task automatic wr(int unsigned a, int unsigned d, string tag);
    regAddr = 8'(a); regWrData = 16'(d); regWrEn = 1'b1;
    step(tag);
  endtask

  task automatic rd(int unsigned a, string tag);
    regAddr = 8'(a);
    step(tag);
  endtask

  task automatic rdAll(string tag);
    rd('h00, tag); rd('h02, tag); rd('h04, tag);
    rd('h06, tag); rd('h08, tag); rd('h0A, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    rdAll("R1");
    rd('h0C, "R1");

    // R3 R5: nothing latches while status-enables are 0
    normPulse = '1; errPulse = '1; rd('h00, "R3");
    rd('h02, "R5");
    rd('h00, "R3");

    // R2: write masks and unmapped addresses
    wr('h04, 'hFFFF, "R2"); wr('h06, 'hFFFF, "R2");
    wr('h08, 'hFFFF, "R2"); wr('h0A, 'hFFFF, "R2");
    rdAll("R2");
    wr('h0C, 'hFFFF, "R2"); rd('h0C, "R2"); rd('h05, "R2"); rd('h01, "R2");
    rdAll("R2");

    // R3: normal pulses, card interrupt maps to bit 8
    normPulse = 7'b100_0101; rd('h00, "R3");
    rd('h00, "R9");

    // R4: card insertion and removal
    cardPresent = 1'b1; rd('h00, "R4");
    rd('h00, "R4");
    cardPresent = 1'b0; rd('h00, "R4");
    rd('h00, "R4");

    // R6: write 0 keeps, write 1 clears
    wr('h00, 'h0000, "R6"); rd('h00, "R6");
    wr('h00, 'h0001, "R6"); rd('h00, "R6");
    wr('h00, 'hFFFF, "R6"); rd('h00, "R9"); rd('h00, "R9");

    // R7: event in the same cycle as its clear
    normPulse = 7'b000_0010; rd('h00, "R7");
    normPulse = 7'b000_0010; wr('h00, 'h0002, "R7");
    rd('h00, "R7");
    wr('h00, 'h0002, "R7"); rd('h00, "R7");

    // R6: disabling status-enable keeps latched bits, blocks new ones
    normPulse = 7'b000_1000; rd('h00, "R6");
    wr('h04, 'h0000, "R6"); rd('h00, "R6");
    normPulse = '1; rd('h00, "R6"); rd('h00, "R6");
    wr('h00, 'hFFFF, "R6"); wr('h04, 'hFFFF, "R6"); rd('h00, "R6");

    // R8: error summary
    errPulse = 9'h021; rd('h00, "R8");
    rd('h02, "R5");
    wr('h00, 'h8000, "R8"); rd('h00, "R8");
    wr('h02, 'h0001, "R8"); rd('h00, "R8");
    wr('h02, 'h0020, "R8"); rd('h00, "R8"); rd('h00, "R9");

    // R10: masking by normal signal-enable
    errPulse = 9'h100; normPulse = 7'b000_0001; rd('h00, "R10");
    wr('h08, 'h0000, "R10"); rd('h00, "R10"); rd('h00, "R10");
    wr('h08, 'h8000, "R9"); rd('h00, "R9"); rd('h00, "R9");
    wr('h0A, 'h0000, "R9"); rd('h00, "R9"); rd('h00, "R9");
    wr('h08, 'h0001, "R9"); rd('h00, "R9"); rd('h00, "R9");
    wr('h00, 'hFFFF, "R9"); wr('h02, 'hFFFF, "R9"); rd('h00, "R9"); rd('h00, "R1");

    // R9: random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      sel = $urandom_range(0, 7);
      regAddr = (sel < 6) ? 8'(sel * 2) : ((sel == 6) ? 8'h0C : 8'h03);
      regWrEn = ($urandom_range(0, 3) == 0);
      regWrData = 16'($urandom);
      normPulse = ($urandom_range(0, 2) == 0) ? 7'($urandom) : '0;
      errPulse  = ($urandom_range(0, 3) == 0) ? 9'($urandom) : '0;
      if ($urandom_range(0, 15) == 0) cardPresent = ~cardPresent;
      step("R9");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule